// File: doc/BRIEF.md
# Raster Panel Frame Sequencer

This block produces the frame-level timing for a raster display controller that drives either passive (dual-scan style) or active (thin-film) panels. It advances on a pixel-clock enable and splits time into line periods of a fixed length. Each line period has `PPL` pixel slots followed by one line-pulse slot. Over a frame it steps through a leading wait, the visible lines, a trailing wait and a sync interval. From that position it drives a frame signal, a line clock, a pixel-valid strobe and a one-clock frame-done pulse.

The frame signal depends on the panel type. For a passive panel, the frame signal covers exactly the first visible line of each frame. A gap of line periods, with the line clock running, then separates frames. For an active panel, the frame signal is a sync pulse. It sits between a trailing wait, during which the line clock is held low, and a leading wait, during which the line clock keeps pulsing. The block samples the mode and count inputs only when a frame starts, so software may rewrite them at any time.

Top module: `lcd_frame_seq`

## Requirements
- R1: While `enable` is low, all four outputs are low. On the first clock edge with `enable` high, a new frame starts at slot 0 of its first line, whatever `pix_ce` is.
- R2: Each line period lasts `PPL`+1 pixel ticks. `pix_valid_o` is high in slots 0..`PPL`-1 of every visible line. `line_o` is high in slot `PPL`.
- R3: Each frame has `cfg_lpp`+1 visible lines.
- R4: In passive mode (`cfg_active`=0), `frame_o` rises at slot 0 of the first visible line. It stays high through that whole line, including its line pulse, and falls at slot 0 of the second visible line.
- R5: In passive mode, the last visible line is followed by `cfg_vsw`+1 gap lines with line pulses and `frame_o` low. `cfg_efw` and `cfg_bfw` have no effect.
- R6: In active mode, the last visible line is followed by `cfg_efw` trailing-wait lines. During these lines `line_o`, `frame_o` and `pix_valid_o` stay low.
- R7: In active mode with `cfg_efw`=0, the sync interval begins directly after the last visible line.
- R8: In active mode, `frame_o` is high for exactly `cfg_vsw`+1 line periods after the trailing wait. The line pulses continue during these periods and no pixels are valid.
- R9: In active mode, the sync interval is followed by `cfg_bfw` leading-wait lines with line pulses and no valid pixels before the first visible line. With `cfg_bfw`=0 this wait is skipped.
- R10: The configuration inputs are sampled only when a frame starts. A change during a frame takes effect on the following frame.
- R11: `frame_done_o` is high for one clock, in the cycle after the tick that ends the last visible line's line-pulse slot.
- R12: Nothing advances in a cycle with `pix_ce` low; the outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; low forces idle with outputs low |
| pix_ce | input | 1 | Pixel-clock enable; one slot per high cycle |
| cfg_active | input | 1 | Panel type: 1 active, 0 passive |
| cfg_lpp | input | LPP_W | Visible lines per frame minus one |
| cfg_vsw | input | VSW_W | Sync (active) or gap (passive) length minus one, in lines |
| cfg_efw | input | WAIT_W | Trailing-wait lines, active mode only |
| cfg_bfw | input | WAIT_W | Leading-wait lines, active mode only |
| frame_o | output | 1 | Frame clock (passive) or vertical sync (active) |
| line_o | output | 1 | Line clock pulse |
| pix_valid_o | output | 1 | Pixel slot valid |
| frame_done_o | output | 1 | One-clock pulse after the last visible line |

## Verification
The hardest situation to reach is a configuration rewritten partway through a frame, which must not disturb that frame. The bench reaches it without special scaffolding. It applies each new configuration in the cycle just after a frame boundary, so every configuration runs first against a frame that was latched with the previous values. A bench model that latches only at boundaries catches any early use. An irregular `pix_ce` pattern, plus runs held entirely high or low, places the stalls inside wait lines and on line-pulse slots. This shows that the trailing-wait suppression and the frame-done timing follow ticks and not clocks.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    // Frame phases; PH_SYNC doubles as the inter-frame gap in passive mode
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_BOF   = 3'd1,
        PH_LINES = 3'd2,
        PH_EOF   = 3'd3,
        PH_SYNC  = 3'd4
    } phase_e;

    typedef struct packed {
        logic frame;
        logic line;
        logic pix;
        logic done;
    } lcd_out_t;

endpackage

// File: rtl/lcd_slot_ctr.sv
module lcd_slot_ctr #(
    parameter int PPL    = 16,
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    output logic [SLOT_W-1:0] slot,
    output logic              eol
);

    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(PPL);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
    } ctr_st_t;

    ctr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.slot = '0;
        end else if (tick) begin
            st_d.slot = (st_q.slot == LAST) ? '0 : st_q.slot + SLOT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slot = st_q.slot;
    assign eol  = (st_q.slot == LAST);

    // R2
    slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.slot <= LAST);

    // R12
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(st_q.slot));

endmodule

// File: rtl/lcd_phase_fsm.sv
module lcd_phase_fsm
    import lcd_seq_pkg::*;
#(
    parameter int LPP_W  = 10,
    parameter int VSW_W  = 6,
    parameter int WAIT_W = 8,
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tick,
    input  logic              eol,
    input  logic              cfg_active,
    input  logic [LPP_W-1:0]  cfg_lpp,
    input  logic [VSW_W-1:0]  cfg_vsw,
    input  logic [WAIT_W-1:0] cfg_efw,
    input  logic [WAIT_W-1:0] cfg_bfw,
    output phase_e            phase,
    output logic [LINE_W-1:0] line,
    output logic              act_mode,
    output logic              running,
    output logic              done
);

    typedef struct packed {
        phase_e            phase;
        logic [LINE_W-1:0] line;
        logic              act;
        logic [LPP_W-1:0]  lpp;
        logic [VSW_W-1:0]  vsw;
        logic [WAIT_W-1:0] efw;
        logic [WAIT_W-1:0] bfw;
        logic              done;
    } fsm_st_t;

    fsm_st_t st_d, st_q;

    logic              reload;
    logic              step;
    logic [LINE_W-1:0] last_bof;
    logic [LINE_W-1:0] last_eof;
    logic [LINE_W-1:0] last_vis;
    logic [LINE_W-1:0] last_sync;

    assign step      = tick && eol;
    assign last_bof  = LINE_W'(st_q.bfw) - LINE_W'(1);
    assign last_eof  = LINE_W'(st_q.efw) - LINE_W'(1);
    assign last_vis  = LINE_W'(st_q.lpp);
    assign last_sync = LINE_W'(st_q.vsw);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        reload    = 1'b0;

        if (!enable) begin
            st_d.phase = PH_IDLE;
            st_d.line  = '0;
        end else begin
            unique case (st_q.phase)
                PH_IDLE: reload = 1'b1;
                PH_BOF: if (step) begin
                    if (st_q.line == last_bof) begin
                        st_d.phase = PH_LINES;
                        st_d.line  = '0;
                    end else begin
                        st_d.line = st_q.line + LINE_W'(1);
                    end
                end
                PH_LINES: if (step) begin
                    if (st_q.line == last_vis) begin
                        st_d.done  = 1'b1;
                        st_d.line  = '0;
                        st_d.phase = (st_q.act && st_q.efw != '0) ? PH_EOF : PH_SYNC;
                    end else begin
                        st_d.line = st_q.line + LINE_W'(1);
                    end
                end
                PH_EOF: if (step) begin
                    if (st_q.line == last_eof) begin
                        st_d.phase = PH_SYNC;
                        st_d.line  = '0;
                    end else begin
                        st_d.line = st_q.line + LINE_W'(1);
                    end
                end
                PH_SYNC: if (step) begin
                    if (st_q.line == last_sync) begin
                        reload = 1'b1;
                    end else begin
                        st_d.line = st_q.line + LINE_W'(1);
                    end
                end
                default: st_d.phase = PH_IDLE;
            endcase
        end

        // Frame boundary: latch configuration and pick the opening phase
        if (reload) begin
            st_d.act   = cfg_active;
            st_d.lpp   = cfg_lpp;
            st_d.vsw   = cfg_vsw;
            st_d.efw   = cfg_active ? cfg_efw : '0;
            st_d.bfw   = cfg_active ? cfg_bfw : '0;
            st_d.line  = '0;
            st_d.phase = (cfg_active && cfg_bfw != '0) ? PH_BOF : PH_LINES;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase    = st_q.phase;
    assign line     = st_q.line;
    assign act_mode = st_q.act;
    assign running  = (st_q.phase != PH_IDLE);
    assign done     = st_q.done;

    // R1
    idle_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> st_q.phase == PH_IDLE);

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);

    // R5
    eof_active_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_EOF || st_q.phase == PH_BOF) |-> st_q.act);

    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_BOF || st_q.phase == PH_EOF) |=>
            ($stable(st_q.lpp) && $stable(st_q.vsw) && $stable(st_q.act)));

    // R7
    no_eof_when_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_LINES && st_q.efw == '0 && enable) |=>
            st_q.phase != PH_EOF);

endmodule

// File: rtl/lcd_out_decode.sv
module lcd_out_decode
    import lcd_seq_pkg::*;
#(
    parameter int PPL    = 16,
    parameter int SLOT_W = 5,
    parameter int LINE_W = 10
) (
    input  logic              enable,
    input  phase_e            phase,
    input  logic              act_mode,
    input  logic [LINE_W-1:0] line,
    input  logic [SLOT_W-1:0] slot,
    input  logic              done,
    output lcd_out_t          out
);

    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(PPL);

    logic pulse_slot;
    logic first_line;

    assign pulse_slot = (slot == LAST);
    assign first_line = (line == '0);

    always_comb begin
        out       = '0;
        out.pix   = enable && (phase == PH_LINES) && !pulse_slot;
        out.line  = enable && pulse_slot &&
                    (phase == PH_BOF || phase == PH_LINES || phase == PH_SYNC);
        out.frame = enable && (act_mode ? (phase == PH_SYNC)
                                        : (phase == PH_LINES && first_line));
        out.done  = enable && done;
    end

endmodule

// File: rtl/lcd_frame_seq.sv
module lcd_frame_seq
    import lcd_seq_pkg::*;
#(
    parameter int PPL    = 16,
    parameter int LPP_W  = 10,
    parameter int VSW_W  = 6,
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              pix_ce,
    input  logic              cfg_active,
    input  logic [LPP_W-1:0]  cfg_lpp,
    input  logic [VSW_W-1:0]  cfg_vsw,
    input  logic [WAIT_W-1:0] cfg_efw,
    input  logic [WAIT_W-1:0] cfg_bfw,
    output logic              frame_o,
    output logic              line_o,
    output logic              pix_valid_o,
    output logic              frame_done_o
);

    localparam int SLOT_W = $clog2(PPL + 1);
    localparam int LW_A   = (LPP_W > WAIT_W) ? LPP_W : WAIT_W;
    localparam int LINE_W = (LW_A > VSW_W) ? LW_A : VSW_W;

    logic [SLOT_W-1:0] slot;
    logic              eol;
    phase_e            phase;
    logic [LINE_W-1:0] line;
    logic              act_mode;
    logic              running;
    logic              done;
    lcd_out_t          out;

    lcd_slot_ctr #(
        .PPL    (PPL),
        .SLOT_W (SLOT_W)
    ) u_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (running),
        .tick  (pix_ce),
        .slot  (slot),
        .eol   (eol)
    );

    lcd_phase_fsm #(
        .LPP_W  (LPP_W),
        .VSW_W  (VSW_W),
        .WAIT_W (WAIT_W),
        .LINE_W (LINE_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .tick       (pix_ce),
        .eol        (eol),
        .cfg_active (cfg_active),
        .cfg_lpp    (cfg_lpp),
        .cfg_vsw    (cfg_vsw),
        .cfg_efw    (cfg_efw),
        .cfg_bfw    (cfg_bfw),
        .phase      (phase),
        .line       (line),
        .act_mode   (act_mode),
        .running    (running),
        .done       (done)
    );

    lcd_out_decode #(
        .PPL    (PPL),
        .SLOT_W (SLOT_W),
        .LINE_W (LINE_W)
    ) u_dec (
        .enable   (enable),
        .phase    (phase),
        .act_mode (act_mode),
        .line     (line),
        .slot     (slot),
        .done     (done),
        .out      (out)
    );

    assign frame_o      = out.frame;
    assign line_o       = out.line;
    assign pix_valid_o  = out.pix;
    assign frame_done_o = out.done;

    // R6
    eof_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EOF) |-> !(line_o || frame_o || pix_valid_o));

    // R8
    sync_no_pix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode && frame_o) |-> !pix_valid_o);

    // R11
    done_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |-> $past(line_o));

    // R4
    passive_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_mode && pix_valid_o && line != '0) |-> !frame_o);

endmodule

// File: tb/lcd_frame_seq_tb.sv
module lcd_frame_seq_tb;

    localparam int PPL    = 3;
    localparam int LPP_W  = 10;
    localparam int VSW_W  = 6;
    localparam int WAIT_W = 8;
    localparam int S      = PPL + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic pix_ce = 1'b0;
    logic cfg_active = 1'b0;
    logic [LPP_W-1:0]  cfg_lpp = '0;
    logic [VSW_W-1:0]  cfg_vsw = '0;
    logic [WAIT_W-1:0] cfg_efw = '0;
    logic [WAIT_W-1:0] cfg_bfw = '0;
    logic frame_o, line_o, pix_valid_o, frame_done_o;

    always #2.5 clk = ~clk;

    lcd_frame_seq #(.PPL(PPL), .LPP_W(LPP_W), .VSW_W(VSW_W), .WAIT_W(WAIT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .pix_ce(pix_ce),
        .cfg_active(cfg_active), .cfg_lpp(cfg_lpp), .cfg_vsw(cfg_vsw),
        .cfg_efw(cfg_efw), .cfg_bfw(cfg_bfw),
        .frame_o(frame_o), .line_o(line_o), .pix_valid_o(pix_valid_o),
        .frame_done_o(frame_done_o)
    );

    int n_vec = 0;
    int n_fail = 0;

    // Next values applied at the falling edge
    logic nx_enable = 1'b0;
    int   nx_act = 0, nx_lpp = 0, nx_vsw = 0, nx_efw = 0, nx_bfw = 0;
    int   ce_mode = 0;            // 0 irregular, 1 held low, 2 held high
    logic [15:0] lf = 16'hACE1;

    // Model state
    int running = 0, idx = 0, wraps = 0;
    int l_act = 0, l_lpp = 0, l_vsw = 0, l_efw = 0, l_bfw = 0;
    logic exp_done = 1'b0;

    localparam int RG_BOF = 0, RG_LIN = 1, RG_EOF = 2, RG_SYN = 3;

    function automatic int flen();
        return ((l_act ? l_bfw : 0) + l_lpp + 1 + (l_act ? l_efw : 0) + l_vsw + 1) * S;
    endfunction

    task automatic where(input int i, output int rg, output int aline, output int pos);
        int ln, b, e;
        ln  = i / S;
        pos = i % S;
        b   = l_act ? l_bfw : 0;
        e   = l_act ? l_efw : 0;
        aline = ln - b;
        if (ln < b)                    rg = RG_BOF;
        else if (ln < b + l_lpp + 1)   rg = RG_LIN;
        else if (ln < b + l_lpp + 1 + e) rg = RG_EOF;
        else                           rg = RG_SYN;
    endtask

    task automatic latch();
        l_act = nx_act; l_lpp = nx_lpp; l_vsw = nx_vsw;
        l_efw = nx_efw; l_bfw = nx_bfw;
    endtask

    task automatic step();
        int rg, aline, pos;
        logic e_fr, e_ln, e_px, e_dn;
        string tag;
        logic bad;
        @(negedge clk);
        e_fr = 0; e_ln = 0; e_px = 0; e_dn = 0;
        tag = "R1";
        if (enable && running != 0) begin
            where(idx, rg, aline, pos);
            e_px = (rg == RG_LIN) && (pos < PPL);
            e_ln = (pos == PPL) && (rg != RG_EOF);
            e_fr = l_act ? (rg == RG_SYN) : (rg == RG_LIN && aline == 0);
            e_dn = exp_done;
            case (rg)
                RG_BOF: tag = "R9";
                RG_LIN: tag = (!l_act && aline == 0) ? "R4" : (aline == l_lpp ? "R3" : "R2");
                RG_EOF: tag = "R6";
                default: tag = !l_act ? "R5" : (l_efw == 0 ? "R7" : "R8");
            endcase
            if (ce_mode == 1) tag = "R12";
        end
        n_vec++;
        bad = 0;
        if (frame_o !== e_fr) begin
            $display("FAIL %s frame_o idx=%0d: actual %0b expected %0b", tag, idx, frame_o, e_fr); bad = 1;
        end
        if (line_o !== e_ln) begin
            $display("FAIL %s line_o idx=%0d: actual %0b expected %0b", tag, idx, line_o, e_ln); bad = 1;
        end
        if (pix_valid_o !== e_px) begin
            $display("FAIL %s pix_valid_o idx=%0d: actual %0b expected %0b", tag, idx, pix_valid_o, e_px); bad = 1;
        end
        if (frame_done_o !== e_dn) begin
            $display("FAIL R11 frame_done_o idx=%0d: actual %0b expected %0b", idx, frame_done_o, e_dn); bad = 1;
        end
        if (bad) n_fail++;

        // Drive inputs for the coming edge
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        pix_ce     = (ce_mode == 2) ? 1'b1 : (ce_mode == 1) ? 1'b0 : (lf[0] | lf[3]);
        enable     = nx_enable;
        cfg_active = (nx_act != 0);
        cfg_lpp    = LPP_W'(nx_lpp);
        cfg_vsw    = VSW_W'(nx_vsw);
        cfg_efw    = WAIT_W'(nx_efw);
        cfg_bfw    = WAIT_W'(nx_bfw);

        @(posedge clk);
        exp_done = 1'b0;
        if (!enable) begin
            running = 0;
        end else if (running == 0) begin
            running = 1; idx = 0; latch();
        end else if (pix_ce) begin
            where(idx, rg, aline, pos);
            if (rg == RG_LIN && aline == l_lpp && pos == PPL) exp_done = 1'b1;
            idx++;
            if (idx == flen()) begin
                idx = 0; latch(); wraps++;
            end
        end
    endtask

    task automatic run_frames(input int n);
        int target;
        target = wraps + n;
        while (wraps < target) step();
    endtask

    initial begin
        // R1: reset and disabled state
        repeat (3) step();
        rst_n = 1'b1;
        repeat (3) step();

        nx_enable = 1'b1;
        // Sweep; each new setting is applied mid-frame, so it must wait for
        // the next boundary (R10). Passive runs use nonzero waits (R5).
        for (int a = 0; a < 2; a++)
            for (int lp = 0; lp < 3; lp += 2)
                for (int vs = 0; vs < 3; vs += 2)
                    for (int ef = 0; ef < 4; ef++) begin
                        if (ef == 2) continue;
                        for (int bf = 0; bf < 3; bf += 2) begin
                            nx_act = a; nx_lpp = lp; nx_vsw = vs;
                            nx_efw = ef; nx_bfw = bf;
                            run_frames(2);
                        end
                    end

        // R1: disable mid-frame, then restart
        repeat (5) step();
        nx_enable = 1'b0;
        repeat (4) step();
        nx_enable = 1'b1;
        run_frames(1);

        // R12: stall with pix_ce held low mid-frame
        repeat (7) step();
        ce_mode = 1;
        repeat (8) step();
        ce_mode = 2;
        nx_act = 0; nx_lpp = 1; nx_vsw = 1; nx_efw = 5; nx_bfw = 5;
        run_frames(2);
        ce_mode = 0;
        run_frames(1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog: actual still running, expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule